// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns a one-bit sigma-delta bitstream into 16-bit conversion words. Each accepted input bit is read as +1 (bit high) or -1 (bit low). The bits pass through three cascaded integrators, then a decimator, then three comb stages. This gives a (sin x / x)^3 low-pass response whose first notch sits at the output word rate. A two-bit rate code picks the decimation ratio N at run time, which moves the notches without changing the shape of the response. The comb result is divided by N^3 through a multiply by a precomputed reciprocal. It is then rounded, coded as straight binary or offset binary, and clamped to the 16-bit range.

The filter's history is only complete a fixed number of output periods after a disturbance, and the block holds back its data-ready strobe until then. A restart pulse clears all filter state and the decimation phase, so three output periods are enough. A change of rate code keeps the old state and only restarts the phase, so four output periods are needed. The coding select acts only after the filter, so it can change freely between words.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is asserted and until the first word, `result_o` reads 0x0000 and `drdy_o` is low.
- R2: Rate code 2'b00 gives N=384, 2'b01 gives N=320, 2'b10 gives N=38 and 2'b11 gives N=76. One decimation happens per N samples taken with `mod_en_i` high. Bits presented with `mod_en_i` low are ignored.
- R3: Each word equals the (1/N^3)-scaled third-order sinc sum of the +1/-1 mapped samples, so a bitstream whose mean over every N-sample window is m yields the code for m.
- R4: With `bipolar_i`=1 the code is offset binary, 0x8000 + round(m*32768), clamped to 0x0000..0xFFFF (m=1 gives 0xFFFF, m=0 gives 0x8000).
- R5: With `bipolar_i`=0 the code is straight binary, round(m*65536), clamped to 0x0000..0xFFFF (any m<=0 gives 0x0000).
- R6: A `sync_i` pulse clears the filter history and decimation phase and loads the rate code. The first `drdy_o` then follows the third decimation, that is after exactly 3N accepted samples, and never earlier.
- R7: A change of `fsel_i` without `sync_i` reloads N and restarts the phase. The next three decimations produce no `drdy_o`, and the fourth yields a correct word.
- R8: Toggling `bipolar_i` alters only the coding of later words. It causes no suppressed word and no change in the filtered value.
- R9: `drdy_o` is a one-cycle pulse per valid word, and `result_o` holds its value between pulses.
- R10: The internal path is wide enough that a valid comb output never exceeds plus or minus N^3, so full-scale input never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en_i | input | 1 | Modulator sample strobe |
| mod_bit_i | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| fsel_i | input | 2 | Rate code selecting N |
| sync_i | input | 1 | Restart pulse clearing filter state |
| bipolar_i | input | 1 | 1 = offset binary, 0 = straight binary |
| result_o | output | 16 | Conversion word |
| drdy_o | output | 1 | One-cycle data-ready strobe |

## Verification
The hardest case to reach is a rate-code change without a restart. Here stale comb delays and a mismatched tap spacing produce plausible-looking words that must stay hidden for exactly three decimations. The stimulus reaches it by running a long stream at one ratio and then switching the code between strobes while the bitstream continues. The scoreboard expects words only from the fourth decimation on, so any early or missing pulse shows up as a mismatch. The three-period limit after a restart is probed by stopping one accepted sample short of 3N and confirming that no pulse has appeared, after a partial period of opposite data has been fed in first.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER = 3;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic longint cube(input int n);
    return longint'(n) * longint'(n) * longint'(n);
  endfunction

  // round(2^sh / n^3)
  function automatic longint unsigned recip(input int n, input int sh);
    longint unsigned c;
    c = longint'(unsigned'(cube(n)));
    return ((64'd1 << sh) + c / 2) / c;
  endfunction
endpackage

// File: rtl/sinc3_integrators.sv
module sinc3_integrators #(
  parameter int ACC_W = 29,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] last_next
);
  logic signed [ACC_W-1:0] x;
  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] acc_d [ORDER];
  logic signed [ACC_W-1:0] sum   [ORDER];

  assign x = bit_in ? ACC_W'(1) : '1;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign sum[k] = acc_q[k] + x;
    end else begin : g_rest
      assign sum[k] = acc_q[k] + sum[k-1];
    end
  end

  assign last_next = sum[ORDER-1];

  always_comb begin
    for (int k = 0; k < ORDER; k++) begin
      if (clr)     acc_d[k] = '0;
      else if (en) acc_d[k] = sum[k];
      else         acc_d[k] = acc_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORDER; k++) acc_q[k] <= '0;
    end else begin
      for (int k = 0; k < ORDER; k++) acc_q[k] <= acc_d[k];
    end
  end
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs #(
  parameter int ACC_W = 29,
  parameter int ORDER = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    tick,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [ACC_W-1:0] dly_d [ORDER];
  logic signed [ACC_W-1:0] diff  [ORDER];
  logic signed [ACC_W-1:0] out_d;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign diff[k] = din - dly_q[k];
    end else begin : g_rest
      assign diff[k] = diff[k-1] - dly_q[k];
    end
  end

  always_comb begin
    out_d = dout;
    for (int k = 0; k < ORDER; k++) dly_d[k] = dly_q[k];
    if (clr) begin
      out_d = '0;
      for (int k = 0; k < ORDER; k++) dly_d[k] = '0;
    end else if (tick) begin
      out_d    = diff[ORDER-1];
      dly_d[0] = din;
      for (int k = 1; k < ORDER; k++) dly_d[k] = diff[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
    end else begin
      dout <= out_d;
      for (int k = 0; k < ORDER; k++) dly_q[k] <= dly_d[k];
    end
  end
endmodule

// File: rtl/sinc3_scaler.sv
module sinc3_scaler #(
  parameter int ACC_W = 29,
  parameter int K_W   = 49,
  parameter int OUT_W = 16,
  parameter int SH    = 48
) (
  input  logic signed [ACC_W-1:0] cin,
  input  logic        [K_W-1:0]   k,
  input  logic                    bipolar,
  output logic        [OUT_W-1:0] code
);
  localparam int PW = ACC_W + K_W + 1;
  localparam logic signed [PW-1:0] HALF_B = PW'(1) <<< (SH - OUT_W);
  localparam logic signed [PW-1:0] HALF_U = PW'(1) <<< (SH - OUT_W - 1);
  localparam logic signed [PW-1:0] MID    = PW'(1) <<< (OUT_W - 1);
  localparam logic signed [PW-1:0] TOP    = (PW'(1) <<< OUT_W) - PW'(1);

  logic signed [PW-1:0] cin_x, k_x, prod, sc_b, sc_u, val;

  always_comb begin
    cin_x = PW'(cin);
    k_x   = PW'({1'b0, k});
    prod  = cin_x * k_x;
    sc_b  = (prod + HALF_B) >>> (SH - OUT_W + 1);
    sc_u  = (prod + HALF_U) >>> (SH - OUT_W);
    val   = bipolar ? (sc_b + MID) : sc_u;
    if (val < 0)        code = '0;
    else if (val > TOP) code = '1;
    else                code = val[OUT_W-1:0];
  end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int OUT_W          = 16,
  parameter int RATIO_00       = 384,
  parameter int RATIO_01       = 320,
  parameter int RATIO_10       = 38,
  parameter int RATIO_11       = 76,
  parameter int RECIP_SH       = 48,
  parameter int SYNC_PERIODS   = 3,
  parameter int CHANGE_PERIODS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en_i,
  input  logic             mod_bit_i,
  input  logic [1:0]       fsel_i,
  input  logic             sync_i,
  input  logic             bipolar_i,
  output logic [OUT_W-1:0] result_o,
  output logic             drdy_o
);
  localparam int NMAX     = max4(RATIO_00, RATIO_01, RATIO_10, RATIO_11);
  localparam int ACC_W    = ORDER * $clog2(NMAX) + 2;
  localparam int CNT_W    = $clog2(NMAX);
  localparam int K_W      = RECIP_SH + 1;
  localparam int SETTLE_W = $clog2(CHANGE_PERIODS + 1);
  localparam logic [SETTLE_W-1:0] SKIP_SYNC = SETTLE_W'(SYNC_PERIODS - 1);
  localparam logic [SETTLE_W-1:0] SKIP_CHG  = SETTLE_W'(CHANGE_PERIODS - 1);
  localparam logic [K_W-1:0] K_00 = K_W'(recip(RATIO_00, RECIP_SH));
  localparam logic [K_W-1:0] K_01 = K_W'(recip(RATIO_01, RECIP_SH));
  localparam logic [K_W-1:0] K_10 = K_W'(recip(RATIO_10, RECIP_SH));
  localparam logic [K_W-1:0] K_11 = K_W'(recip(RATIO_11, RECIP_SH));
  localparam logic signed [ACC_W-1:0] C_00 = ACC_W'(cube(RATIO_00));
  localparam logic signed [ACC_W-1:0] C_01 = ACC_W'(cube(RATIO_01));
  localparam logic signed [ACC_W-1:0] C_10 = ACC_W'(cube(RATIO_10));
  localparam logic signed [ACC_W-1:0] C_11 = ACC_W'(cube(RATIO_11));

  logic [1:0]              sel_q, sel_d, fsel_q, fsel_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [SETTLE_W-1:0]     settle_q, settle_d;
  logic                    pend_q, pend_d, drdy_d;
  logic [OUT_W-1:0]        result_d, scaled;
  logic [CNT_W-1:0]        n_cur;
  logic [K_W-1:0]          k_cur;
  logic signed [ACC_W-1:0] n3_cur, integ_last, comb_q;
  logic                    disturb, take, at_end, tick;

  always_comb begin
    case (sel_q)
      2'd0:    begin n_cur = CNT_W'(RATIO_00); k_cur = K_00; n3_cur = C_00; end
      2'd1:    begin n_cur = CNT_W'(RATIO_01); k_cur = K_01; n3_cur = C_01; end
      2'd2:    begin n_cur = CNT_W'(RATIO_10); k_cur = K_10; n3_cur = C_10; end
      default: begin n_cur = CNT_W'(RATIO_11); k_cur = K_11; n3_cur = C_11; end
    endcase
  end

  assign disturb = sync_i || (fsel_i != fsel_q);
  assign take    = mod_en_i && !disturb;
  assign at_end  = (cnt_q == n_cur - CNT_W'(1));
  assign tick    = take && at_end;

  sinc3_integrators #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(sync_i), .en(take),
    .bit_in(mod_bit_i), .last_next(integ_last)
  );

  sinc3_combs #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(sync_i), .tick(tick),
    .din(integ_last), .dout(comb_q)
  );

  sinc3_scaler #(.ACC_W(ACC_W), .K_W(K_W), .OUT_W(OUT_W), .SH(RECIP_SH)) u_scale (
    .cin(comb_q), .k(k_cur), .bipolar(bipolar_i), .code(scaled)
  );

  always_comb begin
    sel_d    = sel_q;
    fsel_d   = fsel_q;
    cnt_d    = cnt_q;
    settle_d = settle_q;
    pend_d   = 1'b0;
    drdy_d   = 1'b0;
    result_d = result_o;
    if (disturb) begin
      sel_d    = fsel_i;
      fsel_d   = fsel_i;
      cnt_d    = '0;
      settle_d = sync_i ? SKIP_SYNC : SKIP_CHG;
    end else if (mod_en_i) begin
      if (at_end) begin
        cnt_d = '0;
        if (settle_q != '0) settle_d = settle_q - SETTLE_W'(1);
        else                pend_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    if (pend_q && !disturb) begin
      drdy_d   = 1'b1;
      result_d = scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      fsel_q   <= '0;
      cnt_q    <= '0;
      settle_q <= SKIP_SYNC;
      pend_q   <= 1'b0;
      drdy_o   <= 1'b0;
      result_o <= '0;
    end else begin
      sel_q    <= sel_d;
      fsel_q   <= fsel_d;
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      pend_q   <= pend_d;
      drdy_o   <= drdy_d;
      result_o <= result_d;
    end
  end

  assert_drdy_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drdy_o |=> !drdy_o);
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_o |-> $stable(result_o));
  assert_sync_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !drdy_o);
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_cur);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (comb_q <= n3_cur && comb_q >= -n3_cur));
endmodule

// File: tb/sinc3_decimator_test.sv
module sinc3_decimator_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mod_en_i, mod_bit_i, sync_i, bipolar_i;
  logic [1:0]  fsel_i;
  logic [15:0] result_o;
  logic        drdy_o;

  int checks = 0;
  int errors = 0;
  int ndrdy  = 0;
  int sidx   = 0;
  bit done   = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sinc3_decimator uut (
    .clk(clk), .rst_n(rst_n), .mod_en_i(mod_en_i), .mod_bit_i(mod_bit_i),
    .fsel_i(fsel_i), .sync_i(sync_i), .bipolar_i(bipolar_i),
    .result_o(result_o), .drdy_o(drdy_o)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int code_for(input real m, input bit bip);
    real v;
    v = bip ? 32768.0 + m * 32768.0 : m * 65536.0;
    if (v < 0.0) return 0;
    if (v > 65535.0) return 65535;
    return $rtoi(v + 0.5);
  endfunction

  function automatic bit pat_bit(input int pat, input int i);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (i % 2) == 0;
      default: return (i % 4) != 3;
    endcase
  endfunction

  task automatic expect_words(input string tag, input int code, input int count);
    for (int i = 0; i < count; i++) begin
      exp_q.push_back(code);
      tag_q.push_back(tag);
    end
  endtask

  task automatic feed(input int n, input int pat, input int stride);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mod_en_i  = 1'b1;
      mod_bit_i = pat_bit(pat, sidx);
      sidx++;
      for (int g = 1; g < stride; g++) begin
        @(negedge clk);
        mod_en_i = 1'b0;
      end
    end
    @(negedge clk);
    mod_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_sync(input logic [1:0] code);
    @(negedge clk);
    mod_en_i = 1'b0;
    fsel_i   = code;
    sync_i   = 1'b1;
    @(negedge clk);
    sync_i   = 1'b0;
    sidx     = 0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: pops the scoreboard on every data-ready pulse
  always @(negedge clk) begin
    if (rst_n === 1'b1 && drdy_o === 1'b1) begin
      ndrdy++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 unexpected drdy actual=0x%0h expected=none", result_o);
      end else begin
        check_eq(tag_q.pop_front(), int'(result_o), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; mod_en_i = 1'b0; mod_bit_i = 1'b0;
    sync_i = 1'b0; bipolar_i = 1'b1; fsel_i = 2'b00;
    idle(3);
    check_eq("R1 result in reset", int'(result_o), 0);
    check_eq("R1 drdy in reset", int'(drdy_o), 0);
    rst_n = 1'b1;
    idle(2);
    check_eq("R1 result after reset", int'(result_o), 0);
    check_eq("R1 drdy after reset", int'(drdy_o), 0);

    // R4 full-scale positive saturates, N=384 (R2 code 00)
    do_sync(2'b00);
    expect_words("R4 bipolar full scale", code_for(1.0, 1), 3);
    feed(5 * 384, 1, 1);
    idle(6);

    // R3 mean 0.5 at N=320, then R8 coding swap without restart
    do_sync(2'b01);
    expect_words("R3 mean half bipolar", code_for(0.5, 1), 2);
    feed(4 * 320, 3, 1);
    idle(6);
    bipolar_i = 1'b0;
    expect_words("R8 coding switched", code_for(0.5, 0), 2);
    feed(2 * 320, 3, 1);
    idle(6);

    // R7 rate change without sync: first three decimations hidden
    bipolar_i = 1'b1;
    @(negedge clk);
    fsel_i = 2'b11;
    expect_words("R7 after code change", code_for(0.5, 1), 3);
    feed(6 * 76, 3, 1);
    idle(6);

    // R2 sparse strobe at N=38, alternating bits give mid-scale
    do_sync(2'b10);
    expect_words("R2 sparse strobe N38", code_for(0.0, 1), 3);
    feed(5 * 38, 2, 3);
    idle(6);

    // R5 negative mean clamps to zero in straight binary
    bipolar_i = 1'b0;
    do_sync(2'b10);
    expect_words("R5 unipolar clamp low", code_for(-1.0, 0), 1);
    feed(3 * 38, 0, 1);
    idle(6);

    // R6 partial period of zeros, restart, then exactly 3N samples of ones
    feed(20, 0, 1);
    do_sync(2'b10);
    expect_words("R6 first word after sync", code_for(1.0, 0), 1);
    base = ndrdy;
    feed(3 * 38 - 1, 1, 1);
    idle(4);
    check_eq("R6 no word before 3N", ndrdy, base);
    feed(1, 1, 1);
    idle(4);
    check_eq("R6 word at 3N", ndrdy, base + 1);

    idle(10);
    check_eq("R9 all expected words seen", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule